// File: doc/BRIEF.md
# CAN Error Counter Fault Confinement

This block keeps the transmit and receive error counters of a CAN node and derives from them the node's fault-confinement state. Error and success events from the protocol engine raise or lower the counters. Software may also load both counters directly. A comparator with two selectable thresholds raises a warning flag when either counter runs high.

The state machine has three states. FC_ACTIVE is error active, coded 2'b00. FC_PASSIVE is error passive, coded 2'b01. FC_BUSOFF is bus off, coded 2'b10. The transitions are:
- ACTIVE→PASSIVE when either counter rises above 127.
- PASSIVE→ACTIVE when both counters fall to 127 or below.
- ACTIVE or PASSIVE→BUSOFF when the transmit counter rises above 255.
- BUSOFF→ACTIVE when an external recovery-done pulse arrives. That recovery also clears both counters.

The next state is computed from the next counter values, so the state always matches the counters in the same cycle. While the node is in bus off, the software-access flag is low. In that state, software writes and counter events are ignored.

Top module: `can_fault_conf`

## Requirements
- R1: After reset both counters are 0, `conf_state` is 2'b00 (active), `sw_access` is 1, `bus_off` is 0 and `warn` is 0.
- R2: Outside bus off, `tx_err` adds 8 to the transmit counter and `rx_err` adds 1 to the receive counter. `tx_ok` and `rx_ok` each subtract 1, and a counter at 0 stays at 0. When an increment and a decrement arrive in the same cycle, the increment is applied first and the decrement second. Each event takes effect at the next clock edge.
- R3: Counters are 9 bits wide and saturate at 511; they never wrap.
- R4: `conf_state` becomes 2'b01 (passive) when either counter is above 127 and the transmit counter is at most 255. It returns to 2'b00 once both counters are at most 127.
- R5: When the transmit counter exceeds 255, `conf_state` becomes 2'b10 (bus off), `bus_off` goes to 1 and `sw_access` goes to 0.
- R6: `warn` is 1 when either counter exceeds 95 while `warn_sel` is 0, or exceeds 127 while `warn_sel` is 1.
- R7: Outside bus off, a pulse on `sw_wr` loads `sw_tec` and `sw_rec`, zero-extended, into the counters. The state and the warning are re-evaluated from the loaded values in the same cycle. Writing 0 returns the node to active and clears `warn`, and writing 129 to the transmit counter makes it passive.
- R8: A software write takes priority over error and success events that arrive in the same cycle.
- R9: In bus off, `sw_wr`, error events and success events have no effect on the counters or on the state.
- R10: A `recov_done` pulse in bus off clears both counters, returns the node to active and sets `sw_access` to 1. A `recov_done` pulse outside bus off has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_err | input | 1 | Transmit error event |
| tx_ok | input | 1 | Successful transmission event |
| rx_err | input | 1 | Receive error event |
| rx_ok | input | 1 | Successful reception event |
| sw_wr | input | 1 | Software load strobe for both counters |
| sw_tec | input | 8 | Value loaded into the transmit counter |
| sw_rec | input | 8 | Value loaded into the receive counter |
| warn_sel | input | 1 | Warning threshold select: 0 selects 95, 1 selects 127 |
| recov_done | input | 1 | Pulse marking the end of bus-off recovery |
| tec | output | 9 | Transmit error counter |
| rec | output | 9 | Receive error counter |
| conf_state | output | 2 | Confinement state: 00 active, 01 passive, 10 bus off |
| bus_off | output | 1 | Node is in bus off |
| sw_access | output | 1 | Software may write the counters |
| warn | output | 1 | Error count exceeded warning |

## Verification
The assertions assume that every input changes only between clock edges. They also assume that `recov_done` is a single-cycle pulse whose meaning is fixed by the current state. The increment step checks are armed only when no software write and no opposing decrement arrive in the same cycle, and only while the counter has room for a full step. The stimulus drives every input once per cycle, half a period away from the sampling edge. It issues recovery pulses both inside and outside bus off. It mixes concurrent events only in the write-priority and net-step cases named by the requirements.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'b00,
        FC_PASSIVE = 2'b01,
        FC_BUSOFF  = 2'b10
    } fc_state_e;

endpackage

// File: rtl/fc_err_counter.sv
// Saturating error counter with load, hold and clear.
// Priority: clear, hold, load, then the increment/decrement pair.
module fc_err_counter #(
    parameter int CNT_W    = 9,
    parameter int WR_W     = 8,
    parameter int INC_STEP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hold,
    input  logic             ld,
    input  logic [WR_W-1:0]  ld_val,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d
);
    localparam int SUM_W   = CNT_W + 1;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic [SUM_W-1:0] sum_inc;
    logic [SUM_W-1:0] sum_sat;
    logic [SUM_W-1:0] sum_fin;

    // increment first (with saturation), then decrement with floor at zero
    always_comb begin
        sum_inc = {1'b0, cnt_q} + (inc ? SUM_W'(INC_STEP) : '0);
        sum_sat = (sum_inc > SUM_W'(CNT_MAX)) ? SUM_W'(CNT_MAX) : sum_inc;
        sum_fin = (dec && (sum_sat != '0)) ? sum_sat - SUM_W'(1) : sum_sat;
    end

    always_comb begin
        if (clr) begin
            cnt_d = '0;
        end else if (hold) begin
            cnt_d = cnt_q;
        end else if (ld) begin
            cnt_d = CNT_W'(ld_val);
        end else begin
            cnt_d = sum_fin[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/fc_state_fsm.sv
// Confinement state machine, evaluated on the counters' next values.
module fc_state_fsm
    import can_fc_pkg::*;
#(
    parameter int CNT_W   = 9,
    parameter int PAS_LIM = 127,
    parameter int OFF_LIM = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tec_d,
    input  logic [CNT_W-1:0] rec_d,
    input  logic             recov_done,
    output logic [1:0]       conf_state,
    output logic             bus_off,
    output logic             sw_access
);
    fc_state_e state_q;
    fc_state_e state_d;
    logic      go_off;
    logic      go_pas;

    always_comb begin
        go_off = (tec_d > CNT_W'(OFF_LIM));
        go_pas = (tec_d > CNT_W'(PAS_LIM)) || (rec_d > CNT_W'(PAS_LIM));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FC_ACTIVE: begin
                if (go_off)      state_d = FC_BUSOFF;
                else if (go_pas) state_d = FC_PASSIVE;
            end
            FC_PASSIVE: begin
                if (go_off)       state_d = FC_BUSOFF;
                else if (!go_pas) state_d = FC_ACTIVE;
            end
            FC_BUSOFF: begin
                if (recov_done) state_d = FC_ACTIVE;
            end
            default: state_d = FC_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FC_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        conf_state = state_q;
        bus_off    = (state_q == FC_BUSOFF);
        sw_access  = (state_q != FC_BUSOFF);
    end

endmodule

// File: rtl/fc_warn_cmp.sv
// Error-count-exceeded flag with selectable threshold.
module fc_warn_cmp #(
    parameter int CNT_W   = 9,
    parameter int WARN_LO = 95,
    parameter int WARN_HI = 127
) (
    input  logic [CNT_W-1:0] tec,
    input  logic [CNT_W-1:0] rec,
    input  logic             warn_sel,
    output logic             warn
);
    localparam int N_CNT = 2;

    logic [CNT_W-1:0] thr;
    logic [CNT_W-1:0] cnt_arr [N_CNT];
    logic [N_CNT-1:0] over;

    assign thr        = warn_sel ? CNT_W'(WARN_HI) : CNT_W'(WARN_LO);
    assign cnt_arr[0] = tec;
    assign cnt_arr[1] = rec;

    for (genvar gi = 0; gi < N_CNT; gi++) begin : g_cmp
        assign over[gi] = (cnt_arr[gi] > thr);
    end

    assign warn = |over;

endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf #(
    parameter int CNT_W   = 9,
    parameter int WR_W    = 8,
    parameter int TX_STEP = 8,
    parameter int RX_STEP = 1,
    parameter int PAS_LIM = 127,
    parameter int OFF_LIM = 255,
    parameter int WARN_LO = 95,
    parameter int WARN_HI = 127
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_err,
    input  logic             tx_ok,
    input  logic             rx_err,
    input  logic             rx_ok,
    input  logic             sw_wr,
    input  logic [WR_W-1:0]  sw_tec,
    input  logic [WR_W-1:0]  sw_rec,
    input  logic             warn_sel,
    input  logic             recov_done,
    output logic [CNT_W-1:0] tec,
    output logic [CNT_W-1:0] rec,
    output logic [1:0]       conf_state,
    output logic             bus_off,
    output logic             sw_access,
    output logic             warn
);
    logic             cnt_clr;
    logic             cnt_hold;
    logic             cnt_ld;
    logic [CNT_W-1:0] tec_d;
    logic [CNT_W-1:0] rec_d;

    // bus off freezes counters; a recovery pulse there clears them
    assign cnt_clr  = bus_off & recov_done;
    assign cnt_hold = bus_off & ~recov_done;
    assign cnt_ld   = sw_wr & sw_access;

    fc_err_counter #(
        .CNT_W(CNT_W), .WR_W(WR_W), .INC_STEP(TX_STEP)
    ) u_tec (
        .clk(clk), .rst_n(rst_n),
        .clr(cnt_clr), .hold(cnt_hold), .ld(cnt_ld), .ld_val(sw_tec),
        .inc(tx_err), .dec(tx_ok),
        .cnt_q(tec), .cnt_d(tec_d)
    );

    fc_err_counter #(
        .CNT_W(CNT_W), .WR_W(WR_W), .INC_STEP(RX_STEP)
    ) u_rec (
        .clk(clk), .rst_n(rst_n),
        .clr(cnt_clr), .hold(cnt_hold), .ld(cnt_ld), .ld_val(sw_rec),
        .inc(rx_err), .dec(rx_ok),
        .cnt_q(rec), .cnt_d(rec_d)
    );

    fc_state_fsm #(
        .CNT_W(CNT_W), .PAS_LIM(PAS_LIM), .OFF_LIM(OFF_LIM)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .tec_d(tec_d), .rec_d(rec_d), .recov_done(recov_done),
        .conf_state(conf_state), .bus_off(bus_off), .sw_access(sw_access)
    );

    fc_warn_cmp #(
        .CNT_W(CNT_W), .WARN_LO(WARN_LO), .WARN_HI(WARN_HI)
    ) u_warn (
        .tec(tec), .rec(rec), .warn_sel(warn_sel), .warn(warn)
    );

endmodule

// File: rtl/fc_conf_chk.sv
module fc_conf_chk #(
    parameter int CNT_W   = 9,
    parameter int WR_W    = 8,
    parameter int TX_STEP = 8,
    parameter int PAS_LIM = 127,
    parameter int OFF_LIM = 255
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_err,
    input logic             tx_ok,
    input logic             rx_err,
    input logic             rx_ok,
    input logic             sw_wr,
    input logic [WR_W-1:0]  sw_tec,
    input logic [WR_W-1:0]  sw_rec,
    input logic             recov_done,
    input logic [CNT_W-1:0] tec,
    input logic [CNT_W-1:0] rec,
    input logic [1:0]       conf_state
);
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    // R2
    tec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conf_state != 2'b10 && !sw_wr && tx_err && !tx_ok &&
         tec <= CNT_W'(CNT_MAX - TX_STEP))
        |=> tec == $past(tec) + CNT_W'(TX_STEP));

    // R3
    rec_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conf_state != 2'b10 && !sw_wr && rx_err && !rx_ok)
        |=> rec >= $past(rec));

    // R4
    passive_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conf_state == 2'b01
        |-> (tec > CNT_W'(PAS_LIM) || rec > CNT_W'(PAS_LIM)) && tec <= CNT_W'(OFF_LIM));

    // R7
    write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conf_state != 2'b10 && sw_wr)
        |=> tec == CNT_W'($past(sw_tec)) && rec == CNT_W'($past(sw_rec)));

    // R9
    busoff_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conf_state == 2'b10 && !recov_done)
        |=> $stable(tec) && $stable(rec) && conf_state == 2'b10);

    // R10
    recov_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conf_state == 2'b10 && recov_done)
        |=> tec == '0 && rec == '0 && conf_state == 2'b00);

endmodule

bind can_fault_conf fc_conf_chk #(
    .CNT_W(CNT_W), .WR_W(WR_W), .TX_STEP(TX_STEP),
    .PAS_LIM(PAS_LIM), .OFF_LIM(OFF_LIM)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_err(tx_err), .tx_ok(tx_ok),
    .rx_err(rx_err), .rx_ok(rx_ok), .sw_wr(sw_wr), .sw_tec(sw_tec),
    .sw_rec(sw_rec), .recov_done(recov_done), .tec(tec), .rec(rec),
    .conf_state(conf_state)
);

// File: tb/sim_can_fault_conf.sv
module sim_can_fault_conf;

    typedef struct packed {
        logic [8:0] tec;
        logic [8:0] rec;
        logic [1:0] st;
        logic       warn;
        logic       acc;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_err = 1'b0, tx_ok = 1'b0, rx_err = 1'b0, rx_ok = 1'b0;
    logic       sw_wr = 1'b0, warn_sel = 1'b0, recov_done = 1'b0;
    logic [7:0] sw_tec = '0, sw_rec = '0;
    logic [8:0] tec, rec;
    logic [1:0] conf_state;
    logic       bus_off, sw_access, warn;

    int    n_checks = 0;
    int    n_fail   = 0;
    exp_t  exp_q [$];
    string tag_q [$];
    int    m_tec = 0, m_rec = 0, m_st = 0;

    always #5 clk = ~clk;

    can_fault_conf u0 (
        .clk(clk), .rst_n(rst_n), .tx_err(tx_err), .tx_ok(tx_ok),
        .rx_err(rx_err), .rx_ok(rx_ok), .sw_wr(sw_wr), .sw_tec(sw_tec),
        .sw_rec(sw_rec), .warn_sel(warn_sel), .recov_done(recov_done),
        .tec(tec), .rec(rec), .conf_state(conf_state), .bus_off(bus_off),
        .sw_access(sw_access), .warn(warn)
    );

    function automatic int upd(int v, bit inc, int stp, bit dec);
        int r;
        r = v + (inc ? stp : 0);
        if (r > 511) r = 511;
        if (dec && r > 0) r = r - 1;
        return r;
    endfunction

    task automatic step(input bit te, to, re, ro, wr, input int wt, wrc,
                        input bit rd, sel, input string tag);
        exp_t e;
        int   thr;
        @(negedge clk);
        tx_err = te; tx_ok = to; rx_err = re; rx_ok = ro;
        sw_wr = wr; sw_tec = wt[7:0]; sw_rec = wrc[7:0];
        recov_done = rd; warn_sel = sel;
        if (m_st == 2) begin
            if (rd) begin m_tec = 0; m_rec = 0; m_st = 0; end
        end else begin
            if (wr) begin
                m_tec = wt; m_rec = wrc;
            end else begin
                m_tec = upd(m_tec, te, 8, to);
                m_rec = upd(m_rec, re, 1, ro);
            end
            m_st = (m_tec > 255) ? 2 : ((m_tec > 127 || m_rec > 127) ? 1 : 0);
        end
        thr    = sel ? 127 : 95;
        e.tec  = 9'(m_tec);
        e.rec  = 9'(m_rec);
        e.st   = 2'(m_st);
        e.warn = (m_tec > thr) || (m_rec > thr);
        e.acc  = (m_st != 2);
        @(posedge clk);
        #1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input bit sel, input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, sel, tag);
    endtask

    task automatic wr(input int wt, wrc, input bit sel, input string tag);
        step(0, 0, 0, 0, 1, wt, wrc, 0, sel, tag);
    endtask

    // monitor: compares each expected item after its edge has settled
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (exp_q.size() > 0) begin
                exp_t  e;
                exp_t  a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a.tec = tec; a.rec = rec; a.st = conf_state;
                a.warn = warn; a.acc = sw_access;
                n_checks++;
                if (a !== e || bus_off !== (e.st == 2'b10)) begin
                    n_fail++;
                    $display("FAIL %s: actual tec=%0d rec=%0d st=%0d warn=%0b acc=%0b bo=%0b expected tec=%0d rec=%0d st=%0d warn=%0b acc=%0b",
                             t, a.tec, a.rec, a.st, a.warn, a.acc, bus_off,
                             e.tec, e.rec, e.st, e.warn, e.acc);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk);
        #3;
        // R1 reset state
        n_checks++;
        if (tec !== 0 || rec !== 0 || conf_state !== 2'b00 || sw_access !== 1'b1
            || bus_off !== 1'b0 || warn !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: actual tec=%0d rec=%0d st=%0d acc=%0b bo=%0b warn=%0b expected 0 0 0 1 0 0",
                     tec, rec, conf_state, sw_access, bus_off, warn);
        end

        // R2 steps, floor and net step
        repeat (3) step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R2 tx_err +8");
        repeat (2) step(0, 0, 1, 0, 0, 0, 0, 0, 0, "R2 rx_err +1");
        step(0, 1, 0, 0, 0, 0, 0, 0, 0, "R2 tx_ok -1");
        repeat (3) step(0, 0, 0, 1, 0, 0, 0, 0, 0, "R2 rx_ok floor at 0");
        step(1, 1, 0, 0, 0, 0, 0, 0, 0, "R2 net inc+dec");

        // R6 / R7 warning and writes
        wr(96, 0, 0, "R6 R7 write 96 warn at lo threshold");
        idle(1, "R6 hi threshold clears warn");
        wr(128, 0, 1, "R4 R7 write 128 passive");
        wr(129, 0, 1, "R7 write 129 passive");
        wr(0, 0, 0, "R7 write 0 active, warn clear");
        wr(0, 200, 1, "R4 rec 200 passive");
        repeat (73) step(0, 0, 0, 1, 0, 0, 0, 0, 1, "R4 rec decay to active");
        idle(0, "R4 active with rec 127");

        // R8 write priority
        step(1, 0, 1, 0, 1, 10, 3, 0, 0, "R8 write beats events");

        // R5 / R9 / R10 bus off
        wr(250, 0, 0, "R7 write 250");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R5 tx_err to bus off");
        wr(0, 0, 0, "R9 write ignored in bus off");
        step(1, 1, 1, 1, 0, 0, 0, 0, 0, "R9 events ignored in bus off");
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, "R10 recovery clears");
        wr(5, 6, 0, "R7 write after recovery");
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, "R10 recov_done outside bus off");

        // R3 saturation
        wr(0, 255, 0, "R7 write rec 255");
        repeat (259) step(0, 0, 1, 0, 0, 0, 0, 0, 0, "R3 rec saturates at 511");
        wr(0, 0, 0, "R7 clear");

        // R5 via repeated transmit errors
        repeat (32) step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R5 tx errors to bus off");
        step(0, 0, 0, 0, 0, 0, 0, 1, 1, "R10 second recovery");
        idle(0, "R1 R10 idle after recovery");

        wait (exp_q.size() == 0);
        #10;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule